// File: doc/BRIEF.md
# SPI Slave Shifter

This block is the serial side of an SPI slave. It never starts a transfer: an external master supplies the serial clock and the active-low select line. The block samples those two lines and the serial data input through two-flop synchronisers into its own system clock. It finds the clock edges there and shifts data in both directions, most significant bit first.

Clock polarity, clock phase and frame length are set locally from one attribute set. The master owns the clock, but the slave must still agree with it on these settings. After every complete frame the received word appears on a parallel output with a one-cycle valid pulse. At the same moment the transmit word for the next frame is taken from a parallel input.

A four-state controller sequences each transfer:

- **ST_IDLE**: the block is not selected.
- **ST_LOAD**: one cycle after select is seen, in which the first transmit word is captured.
- **ST_SHIFT**: bits are moving.
- **ST_DONE**: one cycle after the last sample edge, which presents the word and reloads the transmitter.

The transitions between these states are:

- **IDLE→LOAD**: select is seen while the master-enable input is low.
- **LOAD→SHIFT** and **DONE→SHIFT**: the block is still selected.
- **SHIFT→DONE**: the last sample edge of the frame has arrived.
- **LOAD/SHIFT/DONE→IDLE**: select is lost or master-enable goes high.

The system clock must run at least four times faster than the serial clock.

Top module: `spis_top`

## Requirements
- R1: While `master_en` is 1 the block takes no part in any transfer: `miso_oe` stays 0 and `rx_valid` never pulses, whatever `sck_i` and `mosi_i` do.
- R2: While `ss_n_i` is 1 (deselected), `miso_oe` is 0, `miso_o` is 0 and serial clock edges are ignored.
- R3: A frame is `cfg_len`+1 bits long (`cfg_len` = 0 means 1 bit). The received word is right-aligned in `rx_word`, and the bits above the frame length are 0.
- R4: With `cfg_cpha` = 0, the block samples `mosi_i` on the leading clock edge and changes `miso_o` on the trailing edge. The first bit appears on `miso_o` as soon as the block is selected.
- R5: With `cfg_cpha` = 1, the block changes `miso_o` on the leading edge and samples `mosi_i` on the trailing edge.
- R6: `cfg_cpol` gives the idle level of the serial clock. With 0 the leading edge is rising; with 1 it is falling.
- R7: Both directions are fixed most significant bit first: bit `cfg_len` of the transmit word goes out first, and the first received bit lands in bit `cfg_len` of `rx_word`.
- R8: Deselecting in the middle of a frame discards the partial word, produces no `rx_valid`, and restarts the bit count, so the next frame is received whole.
- R9: With select held across frames, `tx_word` is captured again when a frame completes (`tx_taken` pulses), and the next frame sends that new word.
- R10: `rx_valid` is a single-cycle pulse per completed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | 1 disables slave operation |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample leading edge; 1: sample trailing edge |
| cfg_len | input | LEN_W | Frame length minus one |
| tx_word | input | MAX_BITS | Word to send in the next frame, right-aligned |
| tx_taken | output | 1 | Pulses when `tx_word` is captured |
| sck_i | input | 1 | Serial clock from the master |
| ss_n_i | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for `miso_o` |
| rx_word | output | MAX_BITS | Last received word, right-aligned |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` updates |

## Verification
The bench builds the block with `MAX_BITS` = 8, so `cfg_len` is three bits wide. That small size lets it sweep every frame length from 1 to 8 bits under all four polarity and phase combinations, with data patterns computed from the loop indices. The serial clock half period is five system cycles, which keeps the synchroniser latency inside the window the bench samples in. Back-to-back frames in two modes, a mid-frame deselect, stray clock edges while deselected, and master-enable lockout are each exercised as separate scenarios.

// File: rtl/spis_pkg.sv
package spis_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } spis_state_e;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
    parameter int WIDTH = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/spis_edge.sv
module spis_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic cpol,
    input  logic cpha,
    output logic sample_ev,
    output logic shift_ev
);
    logic sck_d;
    logic rise, fall, lead, trail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    always_comb begin
        rise      = sck_s & ~sck_d;
        fall      = ~sck_s & sck_d;
        lead      = cpol ? fall : rise;
        trail     = cpol ? rise : fall;
        sample_ev = cpha ? trail : lead;
        shift_ev  = cpha ? lead : trail;
    end
endmodule

// File: rtl/spis_datapath.sv
module spis_datapath #(
    parameter int MAX_BITS = 16,
    localparam int LEN_W = $clog2(MAX_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                swallow_set,
    input  logic                active,
    input  logic                sample_ev,
    input  logic                shift_ev,
    input  logic                mosi_s,
    input  logic [MAX_BITS-1:0] tx_word,
    input  logic [LEN_W-1:0]    cfg_len,
    output logic                miso,
    output logic                last_bit,
    output logic [MAX_BITS-1:0] rx_word
);
    logic [MAX_BITS-1:0] tx_sh;
    logic [MAX_BITS-2:0] rx_sh;
    logic [LEN_W-1:0]    cnt;
    logic                swallow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            cnt     <= '0;
            swallow <= 1'b0;
            rx_word <= '0;
        end else if (frame_start) begin
            tx_sh   <= tx_word;
            rx_sh   <= '0;
            cnt     <= '0;
            swallow <= swallow_set;
        end else if (active) begin
            if (sample_ev) begin
                rx_sh <= {rx_sh[MAX_BITS-3:0], mosi_s};
                cnt   <= cnt + 1'b1;
                if (cnt == cfg_len)
                    rx_word <= {rx_sh, mosi_s};
            end
            if (shift_ev) begin
                if (swallow) swallow <= 1'b0;
                else         tx_sh   <= tx_sh << 1;
            end
        end
    end

    always_comb begin
        miso     = tx_sh[cfg_len];
        last_bit = active & sample_ev & (cnt == cfg_len);
    end
endmodule

// File: rtl/spis_top.sv
module spis_top #(
    parameter int MAX_BITS = 16,
    localparam int LEN_W = $clog2(MAX_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                master_en,
    input  logic                cfg_cpol,
    input  logic                cfg_cpha,
    input  logic [LEN_W-1:0]    cfg_len,
    input  logic [MAX_BITS-1:0] tx_word,
    output logic                tx_taken,
    input  logic                sck_i,
    input  logic                ss_n_i,
    input  logic                mosi_i,
    output logic                miso_o,
    output logic                miso_oe,
    output logic [MAX_BITS-1:0] rx_word,
    output logic                rx_valid
);
    import spis_pkg::*;

    spis_state_e state_q, state_d;
    logic [2:0]  pins_s;
    logic        sck_s, ss_n_s, mosi_s;
    logic        sample_ev, shift_ev, last_bit, miso_bit;
    logic        sel, frame_start, swallow_set, active;

    spis_sync #(.WIDTH(3), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_i, ss_n_i, mosi_i}),
        .q     (pins_s)
    );
    assign {sck_s, ss_n_s, mosi_s} = pins_s;

    spis_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (sck_s),
        .cpol      (cfg_cpol),
        .cpha      (cfg_cpha),
        .sample_ev (sample_ev),
        .shift_ev  (shift_ev)
    );

    spis_datapath #(.MAX_BITS(MAX_BITS)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .swallow_set (swallow_set),
        .active      (active),
        .sample_ev   (sample_ev),
        .shift_ev    (shift_ev),
        .mosi_s      (mosi_s),
        .tx_word     (tx_word),
        .cfg_len     (cfg_len),
        .miso        (miso_bit),
        .last_bit    (last_bit),
        .rx_word     (rx_word)
    );

    assign sel = ~ss_n_s & ~master_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (sel) state_d = ST_LOAD;
            ST_LOAD:  state_d = sel ? ST_SHIFT : ST_IDLE;
            ST_SHIFT: if (!sel) state_d = ST_IDLE;
                      else if (last_bit) state_d = ST_DONE;
            ST_DONE:  state_d = sel ? ST_SHIFT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        frame_start = 1'b0;
        swallow_set = 1'b0;
        active      = 1'b0;
        rx_valid    = 1'b0;
        miso_oe     = 1'b1;
        unique case (state_q)
            ST_IDLE:  miso_oe = 1'b0;
            ST_LOAD:  begin
                frame_start = 1'b1;
                swallow_set = cfg_cpha;
            end
            ST_SHIFT: active = 1'b1;
            ST_DONE:  begin
                frame_start = 1'b1;
                swallow_set = 1'b1;
                rx_valid    = 1'b1;
            end
            default:  miso_oe = 1'b0;
        endcase
        tx_taken = frame_start;
        miso_o   = miso_oe & miso_bit;
    end
endmodule

// File: rtl/spis_chk.sv
module spis_chk #(
    parameter int MAX_BITS = 16,
    localparam int LEN_W = $clog2(MAX_BITS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                master_en,
    input logic                ss_n_i,
    input logic [LEN_W-1:0]    cfg_len,
    input logic                miso_oe,
    input logic                rx_valid,
    input logic [MAX_BITS-1:0] rx_word
);
    logic [1:0] ss_hi_cnt, me_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ss_hi_cnt <= '0;
            me_cnt    <= '0;
        end else begin
            ss_hi_cnt <= !ss_n_i ? 2'd0 : (ss_hi_cnt == 2'd3 ? 2'd3 : ss_hi_cnt + 2'd1);
            me_cnt    <= !master_en ? 2'd0 : (me_cnt == 2'd3 ? 2'd3 : me_cnt + 2'd1);
        end
    end

    // R10
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R2
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_hi_cnt == 2'd3) |-> !miso_oe);

    // R1
    master_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (me_cnt == 2'd3) |-> (!miso_oe && !rx_valid));

    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((32'(rx_word) >> (32'(cfg_len) + 32'd1)) == 32'd0));
endmodule

bind spis_top spis_chk #(.MAX_BITS(MAX_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .master_en (master_en),
    .ss_n_i    (ss_n_i),
    .cfg_len   (cfg_len),
    .miso_oe   (miso_oe),
    .rx_valid  (rx_valid),
    .rx_word   (rx_word)
);

// File: tb/spis_top_tb_top.sv
`timescale 1ns/1ps
module spis_top_tb_top;
    localparam int MB = 8;
    localparam int LW = 3;
    localparam int HALF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_en = 1'b0, cpol = 1'b0, cpha = 1'b0;
    logic [LW-1:0] len = '0;
    logic [MB-1:0] tx_word = '0;
    logic sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic tx_taken, miso, miso_oe, rx_valid;
    logic [MB-1:0] rx_word;

    int checks = 0, fails = 0, vcount = 0;
    logic [MB-1:0] last_rx = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spis_top #(.MAX_BITS(MB)) dut_i (
        .clk(clk), .rst_n(rst_n), .master_en(master_en),
        .cfg_cpol(cpol), .cfg_cpha(cpha), .cfg_len(len),
        .tx_word(tx_word), .tx_taken(tx_taken),
        .sck_i(sck), .ss_n_i(ss_n), .mosi_i(mosi),
        .miso_o(miso), .miso_oe(miso_oe),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    always @(negedge clk) if (rx_valid) begin
        vcount++;
        last_rx = rx_word;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // master side of one frame; bits = number of bits
    task automatic frame(input int bits, input logic [MB-1:0] mw, output logic [MB-1:0] got);
        got = '0;
        for (int i = bits - 1; i >= 0; i--) begin
            if (!cpha) begin
                mosi = mw[i];
                cyc(HALF);
                got[i] = miso;
                sck = ~cpol;
                cyc(HALF);
                sck = cpol;
            end else begin
                sck = ~cpol;
                mosi = mw[i];
                cyc(HALF);
                got[i] = miso;
                sck = cpol;
                cyc(HALF);
            end
        end
    endtask

    function automatic logic [MB-1:0] mask(input int bits);
        return MB'((1 << bits) - 1);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [MB-1:0] got, got2, mw, sw, rx1;
        int v0;
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        chk(miso_oe == 0 && rx_valid == 0 && rx_word == 0, "R2 reset", {miso_oe, rx_valid}, 0);

        // R3 R4 R5 R6 R7 sweep
        for (int m = 0; m < 4; m++) begin
            for (int b = 1; b <= MB; b++) begin
                cpol = m[1];
                cpha = m[0];
                sck = cpol;
                len = LW'(b - 1);
                mw = MB'(b * 37 + m * 91 + 5);
                sw = MB'(8'hA5 ^ (b * 29) ^ (m * 3));
                tx_word = sw;
                cyc(3);
                v0 = vcount;
                ss_n = 1'b0;
                cyc(8);
                chk(miso_oe == 1, "R2 oe while selected", miso_oe, 1);
                frame(b, mw, got);
                cyc(8);
                chk(vcount == v0 + 1, "R10 one valid per frame", vcount - v0, 1);
                chk(last_rx == (mw & mask(b)), "R3/R4/R5/R6/R7 rx word", last_rx, mw & mask(b));
                chk(got == (sw & mask(b)), "R4/R5/R6/R7 tx bits", got, sw & mask(b));
                ss_n = 1'b1;
                cyc(4);
                chk(miso_oe == 0 && miso == 0, "R2 released", {miso_oe, miso}, 0);
            end
        end

        // R9 back-to-back frames
        for (int m = 0; m < 4; m += 3) begin
            cpol = m[1];
            cpha = m[0];
            sck = cpol;
            len = LW'(MB - 1);
            tx_word = 8'h3C;
            cyc(3);
            v0 = vcount;
            ss_n = 1'b0;
            cyc(8);
            tx_word = 8'hD2;
            frame(MB, 8'h96, got);
            cyc(2);
            rx1 = last_rx;
            frame(MB, 8'h4B, got2);
            cyc(8);
            chk(rx1 == 8'h96, "R9 first rx", rx1, 8'h96);
            chk(last_rx == 8'h4B, "R9 second rx", last_rx, 8'h4B);
            chk(got == 8'h3C, "R9 first tx", got, 8'h3C);
            chk(got2 == 8'hD2, "R9 reloaded tx", got2, 8'hD2);
            chk(vcount == v0 + 2, "R10 two pulses", vcount - v0, 2);
            ss_n = 1'b1;
            cyc(6);
        end

        // R8 abort mid-frame
        cpol = 1'b0;
        cpha = 1'b0;
        sck = 1'b0;
        len = LW'(MB - 1);
        tx_word = 8'h81;
        cyc(3);
        v0 = vcount;
        ss_n = 1'b0;
        cyc(8);
        frame(3, 8'h07, got);
        cyc(3);
        ss_n = 1'b1;
        cyc(8);
        chk(vcount == v0, "R8 no valid on abort", vcount - v0, 0);
        ss_n = 1'b0;
        cyc(8);
        frame(MB, 8'h5A, got);
        cyc(8);
        chk(vcount == v0 + 1 && last_rx == 8'h5A, "R8 fresh frame rx", last_rx, 8'h5A);
        chk(got == 8'h81, "R8 fresh frame tx", got, 8'h81);
        ss_n = 1'b1;
        cyc(6);

        // R2 clock toggles while deselected are ignored
        v0 = vcount;
        frame(MB, 8'hFF, got);
        cyc(6);
        chk(vcount == v0 && miso_oe == 0, "R2 edges ignored", vcount - v0, 0);
        tx_word = 8'hE7;
        ss_n = 1'b0;
        cyc(8);
        frame(MB, 8'h24, got);
        cyc(8);
        chk(last_rx == 8'h24 && got == 8'hE7, "R2 frame after stray edges", last_rx, 8'h24);
        ss_n = 1'b1;
        cyc(6);

        // R1 master_en lockout
        master_en = 1'b1;
        cyc(2);
        v0 = vcount;
        ss_n = 1'b0;
        cyc(8);
        chk(miso_oe == 0, "R1 oe locked out", miso_oe, 0);
        frame(MB, 8'h33, got);
        cyc(8);
        chk(vcount == v0, "R1 no valid", vcount - v0, 0);
        ss_n = 1'b1;
        master_en = 1'b0;
        cyc(6);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule